// File: doc/BRIEF.md
# Three-Channel Square-Wave, Noise and Level Mixer

This block is the sound core of a programmable sound generator. From a clock enable it derives a master tick, either at the full enabled rate or at half of it. Three square-wave tone dividers and one shared pseudo-random noise source run from that tick. Each channel ANDs its tone and the noise through an active-low enable mask and then drives an amplitude code. The code is either a fixed 4-bit level widened to 5 bits or a live 5-bit envelope value, and a per-channel mode bit chooses between the two.

The register file, the envelope sequencer and the digital-to-analog stage sit outside this block. All control inputs are taken as static register outputs. The asynchronous active-low reset must be released synchronously to `clk` by the surrounding logic.

Top module: `psg_tone_mixer`

## Requirements
- R1: Each channel's tone period TP is 12 bits, with the coarse nibble as bits 11:8 and the fine byte as bits 7:0. The tone square wave inverts once every 8·TP master ticks.
- R2: A tone period of 0 behaves exactly like a tone period of 1, and a noise period of 0 behaves exactly like a noise period of 1.
- R3: When `full_rate` is high, every cycle with `clk_en` high is a master tick. When `full_rate` is low, only every second enabled cycle is a master tick. Cycles with `clk_en` low never advance any divider.
- R4: The noise source is a 17-bit shift register. Once every 16·NP master ticks, all bits shift one place toward bit 0, and bit 0 XOR bit 3 enters at bit 16. The noise bit is bit 0, and reset loads the value 1.
- R5: In `mix_mask`, bits 2:0 disable tone for channels A, B and C, and bits 5:3 disable noise for channels A, B and C. A 0 enables the source. A disabled source counts as 1, and the channel is gated on only when its tone term AND its noise term are both 1.
- R6: A channel with both its tone and its noise disabled drives its selected level constantly.
- R7: In a 5-bit level field (channel A in `level_regs[4:0]`, B in `[9:5]`, C in `[14:10]`), bit 4 = 0 selects the fixed level L in bits 3:0, output as the code {L, L[3]}, so 15 gives 31. Bit 4 = 1 passes `env_level` to the output with no delay.
- R8: After reset, every tone output is low and the noise bit is high.
- R9: A gated-off channel outputs code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Input clock enable |
| full_rate | input | 1 | 1: master tick on each enable; 0: on every second enable |
| tone_fine | input | 24 | Fine tone bytes, channel A in bits 7:0 |
| tone_coarse | input | 12 | Coarse tone nibbles, channel A in bits 3:0 |
| noise_period | input | 5 | Noise period NP |
| mix_mask | input | 6 | Active-low tone (2:0) and noise (5:3) enables |
| level_regs | input | 15 | Three 5-bit level fields (mode bit 4, level 3:0) |
| env_level | input | 5 | Current envelope level |
| amp_a | output | 5 | Channel A amplitude code |
| amp_b | output | 5 | Channel B amplitude code |
| amp_c | output | 5 | Channel C amplitude code |

## Verification
The bench builds the block with its default parameters only: 8-bit fine, 4-bit coarse, 5-bit noise period, 4-bit level and a 17-bit shift register. Small tone periods give toggle intervals of a few hundred cycles, so the bench measures exact intervals on all three channels under random periods. It also measures them with half-rate and gapped master ticks. With the 5-bit noise period, the bench can compare the first noise run lengths after the seed, including the long zero run, against its own shift-register model. Those long zero runs also make the AND gating of tone with noise visible at the outputs.

// File: rtl/psg_pkg.sv
package psg_pkg;
  // number of tone channels, fixed by the three named outputs
  localparam int NUM_CH = 3;
  // default widths
  localparam int FINE_W      = 8;
  localparam int COARSE_W    = 4;
  localparam int NOISE_W     = 5;
  localparam int LVL_W       = 4;
  localparam int LFSR_W      = 17;
  localparam int LFSR_TAP    = 3;
  // master ticks per period unit, as log2
  localparam int TONE_PRE_W  = 3;
  localparam int NOISE_PRE_W = 4;
endpackage

// File: rtl/psg_master_tick.sv
module psg_master_tick (
  input  logic clk,
  input  logic rst_n,
  input  logic clk_en,
  input  logic full_rate,
  output logic tick_o
);
  logic phase_q;
  logic phase_d;

  always_comb begin
    phase_d = phase_q;
    if (clk_en) begin
      phase_d = ~phase_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
    end else begin
      phase_q <= phase_d;
    end
  end

  assign tick_o = clk_en && (full_rate || phase_q);

  // R3
  half_rate_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && !full_rate) |=> (full_rate || !tick_o));

  // R3
  no_tick_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |-> !tick_o);
endmodule

// File: rtl/psg_period_div.sv
module psg_period_div #(
  parameter int PER_W = 12,
  parameter int PRE_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic [PER_W-1:0] per_i,
  output logic             wrap_o
);
  localparam int CNT_W = PER_W + PRE_W;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] lim_m1;
  logic [PER_W-1:0] per_eff;

  // a zero period is treated as one
  always_comb begin
    per_eff = (per_i == '0) ? PER_W'(1) : per_i;
    lim_m1  = {per_eff, {PRE_W{1'b0}}} - CNT_W'(1);
  end

  // >= so that shortening the period takes effect at once
  assign wrap_o = tick_i && (cnt_q >= lim_m1);

  always_comb begin
    cnt_d = cnt_q;
    if (tick_i) begin
      cnt_d = wrap_o ? '0 : cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  // R3
  hold_without_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(cnt_q));
endmodule

// File: rtl/psg_tone_chan.sv
module psg_tone_chan #(
  parameter int PER_W = 12,
  parameter int PRE_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic [PER_W-1:0] per_i,
  output logic             tone_o
);
  logic wrap;
  logic tone_q;
  logic tone_d;

  psg_period_div #(.PER_W(PER_W), .PRE_W(PRE_W)) div_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_i (tick_i),
    .per_i  (per_i),
    .wrap_o (wrap)
  );

  always_comb begin
    tone_d = tone_q;
    if (wrap) begin
      tone_d = ~tone_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tone_q <= 1'b0;
    end else begin
      tone_q <= tone_d;
    end
  end

  assign tone_o = tone_q;

  // R1
  tone_flip_on_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (tone_q != $past(tone_q)));

  // R1
  tone_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(tone_q));
endmodule

// File: rtl/psg_noise_lfsr.sv
module psg_noise_lfsr #(
  parameter int PER_W  = 5,
  parameter int PRE_W  = 4,
  parameter int SR_W   = 17,
  parameter int SR_TAP = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic [PER_W-1:0] per_i,
  output logic             noise_o
);
  logic            shift;
  logic [SR_W-1:0] sr_q;
  logic [SR_W-1:0] sr_d;

  psg_period_div #(.PER_W(PER_W), .PRE_W(PRE_W)) div_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_i (tick_i),
    .per_i  (per_i),
    .wrap_o (shift)
  );

  always_comb begin
    sr_d = sr_q;
    if (shift) begin
      sr_d = {sr_q[0] ^ sr_q[SR_TAP], sr_q[SR_W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= SR_W'(1);
    end else begin
      sr_q <= sr_d;
    end
  end

  assign noise_o = sr_q[0];

  // R4
  sr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sr_q != '0);

  // R4
  sr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !shift |=> $stable(sr_q));
endmodule

// File: rtl/psg_chan_mix.sv
module psg_chan_mix #(
  parameter int LVL_W = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tone_i,
  input  logic           noise_i,
  input  logic           tone_off_i,
  input  logic           noise_off_i,
  input  logic [LVL_W:0] level_i,
  input  logic [LVL_W:0] env_i,
  output logic [LVL_W:0] amp_o
);
  logic           gate;
  logic [LVL_W:0] lvl_sel;

  always_comb begin
    gate = (tone_i | tone_off_i) & (noise_i | noise_off_i);
    if (level_i[LVL_W]) begin
      lvl_sel = env_i;
    end else begin
      lvl_sel = {level_i[LVL_W-1:0], level_i[LVL_W-1]};
    end
    amp_o = gate ? lvl_sel : '0;
  end

  // R6
  both_off_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tone_off_i && noise_off_i && !level_i[LVL_W])
      |-> (amp_o[LVL_W:1] == level_i[LVL_W-1:0]));

  // R7
  fixed_lsb_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !level_i[LVL_W] |-> (amp_o[0] == amp_o[LVL_W]));

  // R9
  tone_low_mutes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tone_off_i && !tone_i) |-> (amp_o == '0));
endmodule

// File: rtl/psg_tone_mixer.sv
module psg_tone_mixer
  import psg_pkg::*;
#(
  parameter int FINE_W      = psg_pkg::FINE_W,
  parameter int COARSE_W    = psg_pkg::COARSE_W,
  parameter int NOISE_W     = psg_pkg::NOISE_W,
  parameter int LVL_W       = psg_pkg::LVL_W,
  parameter int LFSR_W      = psg_pkg::LFSR_W,
  parameter int LFSR_TAP    = psg_pkg::LFSR_TAP,
  parameter int TONE_PRE_W  = psg_pkg::TONE_PRE_W,
  parameter int NOISE_PRE_W = psg_pkg::NOISE_PRE_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clk_en,
  input  logic                         full_rate,
  input  logic [NUM_CH*FINE_W-1:0]     tone_fine,
  input  logic [NUM_CH*COARSE_W-1:0]   tone_coarse,
  input  logic [NOISE_W-1:0]           noise_period,
  input  logic [2*NUM_CH-1:0]          mix_mask,
  input  logic [NUM_CH*(LVL_W+1)-1:0]  level_regs,
  input  logic [LVL_W:0]               env_level,
  output logic [LVL_W:0]               amp_a,
  output logic [LVL_W:0]               amp_b,
  output logic [LVL_W:0]               amp_c
);
  localparam int TONE_W = FINE_W + COARSE_W;
  localparam int AMP_W  = LVL_W + 1;

  logic             mtick;
  logic             noise_bit;
  logic [AMP_W-1:0] amp_w [NUM_CH];

  psg_master_tick mtick_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .clk_en    (clk_en),
    .full_rate (full_rate),
    .tick_o    (mtick)
  );

  psg_noise_lfsr #(
    .PER_W  (NOISE_W),
    .PRE_W  (NOISE_PRE_W),
    .SR_W   (LFSR_W),
    .SR_TAP (LFSR_TAP)
  ) noise_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_i  (mtick),
    .per_i   (noise_period),
    .noise_o (noise_bit)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [TONE_W-1:0] period;
    logic              tone_bit;

    assign period = {tone_coarse[c*COARSE_W +: COARSE_W],
                     tone_fine[c*FINE_W +: FINE_W]};

    psg_tone_chan #(.PER_W(TONE_W), .PRE_W(TONE_PRE_W)) tone_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_i (mtick),
      .per_i  (period),
      .tone_o (tone_bit)
    );

    psg_chan_mix #(.LVL_W(LVL_W)) mix_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .tone_i      (tone_bit),
      .noise_i     (noise_bit),
      .tone_off_i  (mix_mask[c]),
      .noise_off_i (mix_mask[NUM_CH + c]),
      .level_i     (level_regs[c*AMP_W +: AMP_W]),
      .env_i       (env_level),
      .amp_o       (amp_w[c])
    );
  end

  assign amp_a = amp_w[0];
  assign amp_b = amp_w[1];
  assign amp_c = amp_w[2];
endmodule

// File: tb/psg_tone_mixer_tb.sv
module psg_tone_mixer_tb_top;
  logic        clk;
  logic        rst_n;
  logic        clk_en;
  logic        full_rate;
  logic [23:0] tone_fine;
  logic [11:0] tone_coarse;
  logic [4:0]  noise_period;
  logic [5:0]  mix_mask;
  logic [14:0] level_regs;
  logic [4:0]  env_level;
  logic [4:0]  amp_a;
  logic [4:0]  amp_b;
  logic [4:0]  amp_c;

  int  vectors = 0;
  int  miscompares = 0;
  int  cyc = 0;
  bit  gap_mode = 1'b0;
  bit  done = 1'b0;

  psg_tone_mixer dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .clk_en       (clk_en),
    .full_rate    (full_rate),
    .tone_fine    (tone_fine),
    .tone_coarse  (tone_coarse),
    .noise_period (noise_period),
    .mix_mask     (mix_mask),
    .level_regs   (level_regs),
    .env_level    (env_level),
    .amp_a        (amp_a),
    .amp_b        (amp_b),
    .amp_c        (amp_c)
  );

  initial begin
    clk = 1'b0;
    forever #10 clk = ~clk;
  end

  always @(posedge clk) cyc <= cyc + 1;

  // clock enable driver: steady high, or high on every second cycle
  initial begin
    clk_en = 1'b1;
    forever begin
      @(negedge clk);
      if (gap_mode) clk_en = ~clk_en;
      else          clk_en = 1'b1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [4:0] amp_of(input int ch);
    case (ch)
      0:       return amp_a;
      1:       return amp_b;
      default: return amp_c;
    endcase
  endfunction

  function automatic logic [4:0] fixed_code(input logic [3:0] l);
    return {l, l[3]};
  endfunction

  task automatic set_tp(input int ch, input logic [11:0] tp);
    tone_fine[ch*8 +: 8]   = tp[7:0];
    tone_coarse[ch*4 +: 4] = tp[11:8];
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // waits for n output changes on one channel, storing the cycle of each
  task automatic wait_changes(input int ch, input int n, output int t[16]);
    logic [4:0] prev;
    prev = amp_of(ch);
    for (int k = 0; k < n; k++) begin
      int w = 0;
      do begin
        @(negedge clk);
        w++;
      end while (amp_of(ch) == prev && w < 40000);
      prev = amp_of(ch);
      t[k] = cyc;
    end
  endtask

  task automatic meas_tone(input int ch, input int exp, input string req);
    int t[16];
    wait_changes(ch, 3, t);
    chk((t[1] - t[0]) == exp, req, t[1] - t[0], exp);
    chk((t[2] - t[1]) == exp, req, t[2] - t[1], exp);
  endtask

  task automatic noise_runs(input logic [4:0] np, input string req);
    bit s[320];
    int runs[16];
    int t[16];
    int npe;
    logic [16:0] sr;
    int idx;
    int len;
    bit cur;
    sr = 17'd1;
    for (int k = 0; k < 320; k++) begin
      s[k] = sr[0];
      sr = {sr[0] ^ sr[3], sr[16:1]};
    end
    idx = 0; len = 0; cur = s[0];
    for (int k = 0; k < 320 && idx < 16; k++) begin
      if (s[k] == cur) len++;
      else begin
        runs[idx] = len;
        idx++;
        cur = s[k];
        len = 1;
      end
    end
    npe = (np == 0) ? 1 : int'(np);
    noise_period = np;
    mix_mask = 6'b110111;        // noise only on channel A
    level_regs[4:0] = 5'b01111;
    do_reset();
    @(negedge clk);
    chk(amp_a == 5'd31, "R8 noise seed high", amp_a, 31);
    wait_changes(0, 8, t);
    for (int i = 0; i < 7; i++) begin
      chk((t[i+1] - t[i]) == runs[i+1] * 16 * npe, req,
          t[i+1] - t[i], runs[i+1] * 16 * npe);
    end
  endtask

  initial begin
    void'($urandom(32'h5eed));
    rst_n = 1'b0;
    full_rate = 1'b1;
    tone_fine = '0;
    tone_coarse = '0;
    noise_period = 5'd31;
    mix_mask = 6'b101110;  // A tone only, B noise only, C both off
    level_regs = {5'b01111, 5'b01111, 5'b01111};
    env_level = '0;
    for (int c = 0; c < 3; c++) set_tp(c, 12'd100);

    // reset state
    do_reset();
    @(negedge clk);
    chk(amp_a == 5'd0,  "R8 tone starts low", amp_a, 0);
    chk(amp_b == 5'd31, "R8 noise starts high", amp_b, 31);
    chk(amp_c == 5'd31, "R6 both disabled", amp_c, 31);
    repeat (300) @(negedge clk);
    chk(amp_c == 5'd31, "R6 both disabled later", amp_c, 31);

    // tone periods from fine and coarse parts
    mix_mask = 6'b111000;
    set_tp(0, 12'h105);
    meas_tone(0, 8 * 12'h105, "R1 coarse+fine");
    set_tp(1, 12'h003);
    meas_tone(1, 24, "R1 small period");

    // zero period behaves like one
    set_tp(2, 12'h000);
    meas_tone(2, 8, "R2 tone period 0");

    // random tone periods on all channels
    for (int it = 0; it < 6; it++) begin
      int tp[3];
      for (int c = 0; c < 3; c++) begin
        tp[c] = $urandom_range(60, 1);
        set_tp(c, 12'(tp[c]));
      end
      for (int c = 0; c < 3; c++) meas_tone(c, 8 * tp[c], "R1 random period");
    end

    // master clock select and enable gaps
    set_tp(0, 12'd5);
    full_rate = 1'b0;
    meas_tone(0, 80, "R3 half rate");
    gap_mode = 1'b1;
    full_rate = 1'b1;
    meas_tone(0, 80, "R3 gapped enable");
    full_rate = 1'b0;
    meas_tone(0, 160, "R3 gapped half rate");
    gap_mode = 1'b0;
    full_rate = 1'b1;
    @(negedge clk);

    // noise sequence and run lengths
    noise_runs(5'd2, "R4 noise run length");
    noise_runs(5'd0, "R2 noise period 0");

    // tone AND noise on channel A
    begin
      int changes = 0;
      int nonzero = 0;
      logic [4:0] prev;
      mix_mask = 6'b110110;
      noise_period = 5'd31;
      set_tp(0, 12'd1);
      do_reset();
      repeat (20) @(negedge clk);
      prev = amp_a;
      for (int k = 0; k < 420; k++) begin
        @(negedge clk);
        if (amp_a != prev) changes++;
        prev = amp_a;
      end
      chk(changes > 40, "R5 tone passes while noise high", changes, 41);
      repeat (200) @(negedge clk);
      for (int k = 0; k < 1000; k++) begin
        @(negedge clk);
        if (amp_a != 5'd0) nonzero++;
      end
      chk(nonzero == 0, "R9 noise low mutes channel", nonzero, 0);
    end

    // fixed level code on channel C with both sources off
    mix_mask = 6'b111111;
    for (int l = 0; l < 16; l++) begin
      @(negedge clk);
      level_regs[14:10] = {1'b0, 4'(l)};
      #1;
      chk(amp_c == fixed_code(4'(l)), "R7 fixed level code", amp_c, fixed_code(4'(l)));
    end

    // envelope mode passes env_level live
    level_regs[4:0] = 5'b11010;
    for (int k = 0; k < 10; k++) begin
      logic [4:0] e;
      e = 5'($urandom_range(31, 0));
      @(negedge clk);
      env_level = e;
      #1;
      chk(amp_a == e, "R7 envelope level", amp_a, e);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule